// File: doc/BRIEF.md
# Tagged-Token Dataflow Firing Unit

This block is a small dynamic dataflow core with no program counter. A handful of instruction entries sit in a tag-matched store. Each entry holds an operation, two operand slots that can each be marked present, a source tag for each slot and a destination tag. A data token (tag plus value) is compared against the source tags of every live entry at once. Each slot whose tag matches takes the value. A token that matches nothing vanishes; it is never held for a later entry.

Once both slots of an entry are present the entry is ready. A rotating-priority arbiter then picks one ready entry per cycle and sends it on the issue port as a single instruction token: operation, both operand values and destination tag, with a valid/ready handshake. The built-in integer execution unit takes every token accepted on that port. One cycle later it produces a result token tagged with the destination. That result is shown on the result port and also fed straight back into the matcher, so dependent entries fire purely because their data has arrived.

Software loads entries through the load port. Data enters through the token input port, which is stalled for one cycle whenever a result token is being fed back. The entry count must be a power of two.

Top module: `dfu_core`

## Requirements
- R1: An entry with only one of its two operand slots present never produces an instruction token.
- R2: When the last missing operand of a live entry is captured at a clock edge and the issue port is free, `itok_valid` rises at the following clock edge.
- R3: An instruction token carries the entry's operation code on `itok_op`, the value in operand slot A on `itok_a`, the value in slot B on `itok_b` and the destination tag on `itok_dst`.
- R4: A data token writes its value into every operand slot of every live entry whose source tag equals the token tag, including both slots of one entry when both tags are equal.
- R5: Issuing an entry clears both of its present marks, so the entry issues again only after two fresh operands arrive.
- R6: The execution unit computes op 0 = a+b, op 1 = a-b, op 2 = a AND b, op 3 = a XOR b, modulo 2^DATA_W. `res_valid` is high exactly in the cycle after an accepted instruction token, with `res_tag` equal to that token's destination tag.
- R7: A result token is applied to the matcher like any data token, so entries that depend on it fire without outside help.
- R8: When several entries are ready together, they are issued one per accepted cycle in rotating index order, each grant starting the search at the index after the previous winner.
- R9: While `itok_valid` is high and `itok_ready` is low, the instruction token stays valid and all its fields hold their values.
- R10: `tok_ready` is low in every cycle in which `res_valid` is high. An external token offered in that cycle is taken in a later cycle and is not lost.
- R11: After reset no entry is live, `itok_valid` and `res_valid` are low and `tok_ready` is high. A load (`ld_valid`) writes the entry at `ld_idx`, sets its liveness from `ld_live` and clears both of its present marks.
- R12: A data token whose tag matches no live entry is dropped; an entry loaded afterwards with that tag does not see it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Write one entry this cycle |
| ld_idx | input | log2(N_ENT) | Entry index to write |
| ld_live | input | 1 | Liveness of the written entry |
| ld_op | input | 2 | Operation code (0 add, 1 sub, 2 and, 3 xor) |
| ld_tag_a | input | TAG_W | Source tag for operand slot A |
| ld_tag_b | input | TAG_W | Source tag for operand slot B |
| ld_tag_dst | input | TAG_W | Destination tag of the result |
| tok_valid | input | 1 | External data token offered |
| tok_tag | input | TAG_W | External token tag |
| tok_data | input | DATA_W | External token value |
| tok_ready | output | 1 | External token is taken this cycle |
| itok_valid | output | 1 | Instruction token valid |
| itok_ready | input | 1 | Issue port may advance |
| itok_op | output | 2 | Instruction token operation |
| itok_a | output | DATA_W | Instruction token operand A |
| itok_b | output | DATA_W | Instruction token operand B |
| itok_dst | output | TAG_W | Instruction token destination tag |
| res_valid | output | 1 | Result token valid (also fed back) |
| res_tag | output | TAG_W | Result token tag |
| res_data | output | DATA_W | Result token value |

## Verification
The hardest case to reach is an external token meeting a fed-back result in the same cycle, because the result appears only two edges after the last operand of the producing entry. The bench drives a two-entry dependency chain with the issue port always ready and offers the consumer's second operand exactly in the cycle the producer's result returns. It then checks that the stalled token still reaches the consumer. Simultaneous readiness of all four entries is forced by giving them common source tags while the issue port is held off. This exercises the hold behaviour and the rotating grant order in one run. Random operand values and random back-pressure cover the remaining mix.

// File: rtl/dfu_pkg.sv
package dfu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } dfu_op_e;
endpackage

// File: rtl/dfu_store.sv
// Tag-matched instruction store: every live entry compares the incoming tag
// against both source tags in parallel.
module dfu_store
  import dfu_pkg::*;
#(
  parameter int N_ENT  = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic              ld_live,
  input  logic [1:0]        ld_op,
  input  logic [TAG_W-1:0]  ld_tag_a,
  input  logic [TAG_W-1:0]  ld_tag_b,
  input  logic [TAG_W-1:0]  ld_tag_dst,
  input  logic              mt_valid,
  input  logic [TAG_W-1:0]  mt_tag,
  input  logic [DATA_W-1:0] mt_data,
  input  logic              clr_valid,
  input  logic [IDX_W-1:0]  clr_idx,
  output logic [N_ENT-1:0]  rdy,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [1:0]        rd_op,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  output logic [TAG_W-1:0]  rd_dst
);
  logic [N_ENT-1:0]  live, pa, pb;
  dfu_op_e           op [N_ENT];
  logic [TAG_W-1:0]  ta [N_ENT];
  logic [TAG_W-1:0]  tb [N_ENT];
  logic [TAG_W-1:0]  td [N_ENT];
  logic [DATA_W-1:0] va [N_ENT];
  logic [DATA_W-1:0] vb [N_ENT];

  // Priority inside one edge: clear on issue, then match, then load.
  always_ff @(posedge clk) begin
    for (int i = 0; i < N_ENT; i++) begin
      if (rst) begin
        live[i] <= 1'b0;
        pa[i]   <= 1'b0;
        pb[i]   <= 1'b0;
      end else begin
        if (clr_valid && clr_idx == IDX_W'(i)) begin
          pa[i] <= 1'b0;
          pb[i] <= 1'b0;
        end
        if (mt_valid && live[i] && ta[i] == mt_tag) begin
          va[i] <= mt_data;
          pa[i] <= 1'b1;
        end
        if (mt_valid && live[i] && tb[i] == mt_tag) begin
          vb[i] <= mt_data;
          pb[i] <= 1'b1;
        end
        if (ld_valid && ld_idx == IDX_W'(i)) begin
          live[i] <= ld_live;
          op[i]   <= dfu_op_e'(ld_op);
          ta[i]   <= ld_tag_a;
          tb[i]   <= ld_tag_b;
          td[i]   <= ld_tag_dst;
          pa[i]   <= 1'b0;
          pb[i]   <= 1'b0;
        end
      end
    end
  end

  assign rdy    = live & pa & pb;
  assign rd_op  = op[rd_idx];
  assign rd_a   = va[rd_idx];
  assign rd_b   = vb[rd_idx];
  assign rd_dst = td[rd_idx];
endmodule

// File: rtl/dfu_rr_arb.sv
// Rotating-priority pick of one requester; search starts after last winner.
module dfu_rr_arb #(
  parameter int N   = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic          gnt_any,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] ptr;
  logic [IW-1:0] cand;

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    cand    = '0;
    for (int k = N - 1; k >= 0; k--) begin
      cand = ptr + IW'(k);
      if (req[cand]) begin
        gnt_any = 1'b1;
        gnt_idx = cand;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (take && gnt_any) ptr <= gnt_idx + 1'b1;
  end
endmodule

// File: rtl/dfu_alu.sv
// Single-cycle integer unit; result token registered one cycle after go.
module dfu_alu
  import dfu_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [TAG_W-1:0]  dst,
  output logic              res_valid,
  output logic [TAG_W-1:0]  res_tag,
  output logic [DATA_W-1:0] res_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
    end else begin
      res_valid <= go;
      if (go) begin
        res_tag <= dst;
        case (dfu_op_e'(op))
          OP_ADD:  res_data <= a + b;
          OP_SUB:  res_data <= a - b;
          OP_AND:  res_data <= a & b;
          default: res_data <= a ^ b;
        endcase
      end
    end
  end
endmodule

// File: rtl/dfu_core.sv
module dfu_core
  import dfu_pkg::*;
#(
  parameter int N_ENT  = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ld_valid,
  input  logic [$clog2(N_ENT)-1:0] ld_idx,
  input  logic                     ld_live,
  input  logic [1:0]               ld_op,
  input  logic [TAG_W-1:0]         ld_tag_a,
  input  logic [TAG_W-1:0]         ld_tag_b,
  input  logic [TAG_W-1:0]         ld_tag_dst,
  input  logic                     tok_valid,
  input  logic [TAG_W-1:0]         tok_tag,
  input  logic [DATA_W-1:0]        tok_data,
  output logic                     tok_ready,
  output logic                     itok_valid,
  input  logic                     itok_ready,
  output logic [1:0]               itok_op,
  output logic [DATA_W-1:0]        itok_a,
  output logic [DATA_W-1:0]        itok_b,
  output logic [TAG_W-1:0]         itok_dst,
  output logic                     res_valid,
  output logic [TAG_W-1:0]         res_tag,
  output logic [DATA_W-1:0]        res_data
);
  localparam int IDX_W = $clog2(N_ENT);

  logic              mt_valid;
  logic [TAG_W-1:0]  mt_tag;
  logic [DATA_W-1:0] mt_data;
  logic [N_ENT-1:0]  rdy;
  logic              gnt_any;
  logic [IDX_W-1:0]  gnt_idx;
  logic              issue_en, fire;
  logic [1:0]        rd_op;
  logic [DATA_W-1:0] rd_a, rd_b;
  logic [TAG_W-1:0]  rd_dst;

  // Fed-back result takes the matcher; external port waits that cycle.
  assign tok_ready = !res_valid;
  assign mt_valid  = res_valid || tok_valid;
  assign mt_tag    = res_valid ? res_tag  : tok_tag;
  assign mt_data   = res_valid ? res_data : tok_data;

  assign issue_en = !itok_valid || itok_ready;
  assign fire     = issue_en && gnt_any;

  dfu_store #(.N_ENT(N_ENT), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_live(ld_live), .ld_op(ld_op),
    .ld_tag_a(ld_tag_a), .ld_tag_b(ld_tag_b), .ld_tag_dst(ld_tag_dst),
    .mt_valid(mt_valid), .mt_tag(mt_tag), .mt_data(mt_data),
    .clr_valid(fire), .clr_idx(gnt_idx),
    .rdy(rdy), .rd_idx(gnt_idx),
    .rd_op(rd_op), .rd_a(rd_a), .rd_b(rd_b), .rd_dst(rd_dst)
  );

  dfu_rr_arb #(.N(N_ENT)) u_arb (
    .clk(clk), .rst(rst), .req(rdy), .take(issue_en),
    .gnt_any(gnt_any), .gnt_idx(gnt_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      itok_valid <= 1'b0;
    end else if (issue_en) begin
      itok_valid <= gnt_any;
      if (gnt_any) begin
        itok_op  <= rd_op;
        itok_a   <= rd_a;
        itok_b   <= rd_b;
        itok_dst <= rd_dst;
      end
    end
  end

  dfu_alu #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_alu (
    .clk(clk), .rst(rst), .go(itok_valid && itok_ready),
    .op(itok_op), .a(itok_a), .b(itok_b), .dst(itok_dst),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data)
  );
endmodule

// File: rtl/dfu_core_chk.sv
module dfu_core_chk #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tok_ready,
  input logic              itok_valid,
  input logic              itok_ready,
  input logic [1:0]        itok_op,
  input logic [DATA_W-1:0] itok_a,
  input logic [DATA_W-1:0] itok_b,
  input logic [TAG_W-1:0]  itok_dst,
  input logic              res_valid,
  input logic [TAG_W-1:0]  res_tag
);
  // R9: stalled token holds
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    itok_valid && !itok_ready |=> itok_valid && $stable(itok_op) &&
      $stable(itok_a) && $stable(itok_b) && $stable(itok_dst));

  // R6: result one cycle after acceptance
  a_r6_latency: assert property (@(posedge clk) disable iff (rst)
    itok_valid && itok_ready |=> res_valid);

  // R6: no result without an accepted token
  a_r6_cause: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(itok_valid && itok_ready));

  // R6: result carries destination tag
  a_r6_tag: assert property (@(posedge clk) disable iff (rst)
    itok_valid && itok_ready |=> res_tag == $past(itok_dst));

  // R10: input port stalled while result feeds back
  a_r10_stall: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !tok_ready);

  // R11: reset clears outputs
  a_r11_reset: assert property (@(posedge clk)
    rst |=> !itok_valid && !res_valid);
endmodule

bind dfu_core dfu_core_chk #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .tok_ready(tok_ready),
  .itok_valid(itok_valid), .itok_ready(itok_ready), .itok_op(itok_op),
  .itok_a(itok_a), .itok_b(itok_b), .itok_dst(itok_dst),
  .res_valid(res_valid), .res_tag(res_tag)
);

// File: tb/dfu_core_test.sv
`timescale 1ns/1ps
module dfu_core_test;
  localparam int TW = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_valid = 1'b0, ld_live = 1'b0;
  logic [1:0] ld_idx = '0, ld_op = '0;
  logic [TW-1:0] ld_tag_a = '0, ld_tag_b = '0, ld_tag_dst = '0;
  logic tok_valid = 1'b0;
  logic [TW-1:0] tok_tag = '0;
  logic [DW-1:0] tok_data = '0;
  logic tok_ready;
  logic itok_valid;
  logic itok_ready = 1'b1;
  logic [1:0] itok_op;
  logic [DW-1:0] itok_a, itok_b;
  logic [TW-1:0] itok_dst;
  logic res_valid;
  logic [TW-1:0] res_tag;
  logic [DW-1:0] res_data;

  dfu_core uut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int it_n = 0, rs_n = 0, stalls = 0;
  int it_op [8], it_a [8], it_b [8], it_d [8];
  int rs_t [8], rs_d [8];
  bit rnd_bp = 0;
  bit prev_stall = 0;
  int p_op, p_a, p_b, p_d;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int alu_ref(input int op, input int a, input int b);
    case (op)
      0: return (a + b) & 8'hff;
      1: return (a - b) & 8'hff;
      2: return a & b;
      default: return a ^ b;
    endcase
  endfunction

  // monitor: samples 1 ns before each rising edge
  initial forever begin
    @(negedge clk); #4;
    if (!rst) begin
      if (prev_stall) begin
        chk("R9 hold valid", int'(itok_valid), 1);
        chk("R9 hold op", int'(itok_op), p_op);
        chk("R9 hold a", int'(itok_a), p_a);
        chk("R9 hold b", int'(itok_b), p_b);
        chk("R9 hold dst", int'(itok_dst), p_d);
      end
      prev_stall = itok_valid && !itok_ready;
      p_op = itok_op; p_a = itok_a; p_b = itok_b; p_d = itok_dst;
      if (res_valid) chk("R10 tok_ready low with result", int'(tok_ready), 0);
      if (tok_valid && !tok_ready) stalls++;
      if (itok_valid && itok_ready && it_n < 8) begin
        it_op[it_n] = itok_op; it_a[it_n] = itok_a;
        it_b[it_n] = itok_b; it_d[it_n] = itok_dst;
      end
      if (itok_valid && itok_ready) it_n++;
      if (res_valid && rs_n < 8) begin
        rs_t[rs_n] = res_tag; rs_d[rs_n] = res_data;
      end
      if (res_valid) rs_n++;
    end
  end

  // random back-pressure
  initial forever begin
    @(negedge clk);
    if (rnd_bp) itok_ready = 1'($urandom_range(0, 1));
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input int idx, input bit live, input int op,
                      input int ta, input int tb, input int td);
    ld_valid = 1; ld_idx = 2'(idx); ld_live = live; ld_op = 2'(op);
    ld_tag_a = TW'(ta); ld_tag_b = TW'(tb); ld_tag_dst = TW'(td);
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic send(input int tag, input int data);
    tok_valid = 1; tok_tag = TW'(tag); tok_data = DW'(data);
    while (!tok_ready) @(negedge clk);
    @(negedge clk);
    tok_valid = 0;
  endtask

  task automatic clear_rec();
    it_n = 0; rs_n = 0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    wait_n(4);
    chk("R11 reset itok_valid", int'(itok_valid), 0);
    chk("R11 reset res_valid", int'(res_valid), 0);
    chk("R11 reset tok_ready", int'(tok_ready), 1);
    rst = 0;
    wait_n(1);

    // R12 / R1: early token is dropped, half-filled entry stays silent
    clear_rec();
    send(15, 99);
    load(0, 1, 0, 15, 14, 13);
    send(14, 5);
    wait_n(6);
    chk("R12 dropped token / R1 one operand", it_n, 0);
    send(15, 7);
    wait_n(6);
    chk("R11 loaded entry fires", it_n, 1);
    chk("R3 op", it_op[0], 0);
    chk("R3 a", it_a[0], 7);
    chk("R3 b", it_b[0], 5);
    chk("R6 add result", rs_d[0], 12);

    // chain: entry0 consumes entry1's result (tag 3)
    load(0, 1, 3, 3, 4, 6);
    load(1, 1, 0, 1, 2, 3);
    load(2, 0, 0, 0, 0, 0);
    load(3, 0, 0, 0, 0, 0);
    for (int it = 0; it < 20; it++) begin
      int x, y, z, s;
      x = $urandom_range(0, 255); y = $urandom_range(0, 255);
      z = $urandom_range(0, 255);
      s = (x + y) & 8'hff;
      clear_rec();
      if (it == 10) rnd_bp = 1;
      send(1, x);
      send(2, y);
      if (it < 10) begin
        chk("R2 not yet valid", int'(itok_valid), 0);
        wait_n(1);
        chk("R2 valid next edge", int'(itok_valid), 1);
        wait_n(1);
        chk("R6 result one cycle after accept", int'(res_valid), 1);
        send(4, z);                       // collides with fed-back result
        wait_n(10);
      end else begin
        send(4, z);
        wait_n(40);
      end
      chk("R5 exactly two issues", it_n, 2);
      chk("R3 producer op", it_op[0], 0);
      chk("R3 producer a", it_a[0], x);
      chk("R3 producer b", it_b[0], y);
      chk("R3 producer dst", it_d[0], 3);
      chk("R7 consumer a from result", it_a[1], s);
      chk("R10 consumer b after stall", it_b[1], z);
      chk("R6 result tag", rs_t[1], 6);
      chk("R6 xor result", rs_d[1], s ^ z);
    end
    rnd_bp = 0;
    itok_ready = 1;
    chk("R10 stall seen", int'(stalls > 0), 1);

    // R4 broadcast: tag 7 feeds both slots of entry1 and slot A of entry0
    begin
      int v, w;
      v = $urandom_range(0, 255); w = $urandom_range(0, 255);
      load(0, 1, 2, 7, 8, 9);
      load(1, 1, 1, 7, 7, 10);
      wait_n(2);
      clear_rec();
      send(7, v);
      wait_n(6);
      chk("R4 same-tag entry fires", it_n, 1);
      chk("R4 slot a", it_a[0], v);
      chk("R4 slot b", it_b[0], v);
      chk("R6 sub to zero", rs_d[0], 0);
      send(8, w);
      wait_n(6);
      chk("R4 second entry fires", it_n, 2);
      chk("R4 broadcast into other entry", it_a[1], v);
      chk("R6 and result", rs_d[1], v & w);
    end

    // R8 rotating grant, R9 hold, R6 all ops
    for (int e = 0; e < 4; e++) load(e, 1, e, 12, 13, e);
    for (int rep = 0; rep < 5; rep++) begin
      int a, b, h_d;
      a = $urandom_range(0, 255); b = $urandom_range(0, 255);
      clear_rec();
      itok_ready = 0;
      send(12, a);
      send(13, b);
      wait_n(2);
      h_d = itok_dst;
      wait_n(3);
      chk("R9 dst held", int'(itok_dst), h_d);
      itok_ready = 1;
      wait_n(10);
      chk("R8 four grants", it_n, 4);
      for (int k = 0; k < 4; k++) begin
        chk("R3 op matches entry", it_op[k], it_d[k]);
        chk("R3 operand a", it_a[k], a);
        chk("R3 operand b", it_b[k], b);
        chk("R6 op result", rs_d[k], alu_ref(it_d[k], a, b));
        chk("R6 tag", rs_t[k], it_d[k]);
        if (k > 0) chk("R8 rotating order", it_d[k], (it_d[k-1] + 1) % 4);
      end
    end

    summary();
    $finish;
  end
endmodule